// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block runs the start-up sequence of a stereo converter's digital back end after it leaves power-down. While the power-down input is high, it holds everything idle. When that input falls, the block points the modulators at their zero-reference inputs with a select line. It then sums a fixed number of left and right samples taken at the frame (word) rate and divides each sum by the sample count, which gives one offset per channel. Next it waits a fixed number of further frames so the decimation filter can flush the zero-input data. After that it passes data with each channel's offset subtracted.

Every duration is counted in frame strobes, not clock cycles, so the timing scales with the word rate. A busy flag covers both the calibration window and the settling wait. Raising power-down at any moment abandons the sequence and wipes all partial results.

Top module: `offset_cal_seq`

## Requirements
- R1: While `pdIn` is high, `calBusy` and `zeroSel` are low, and from the second consecutive cycle of power-down both outputs are zero.
- R2: A calibration starts only on a high-to-low change of `pdIn`. `calBusy` and `zeroSel` rise at the first clock edge that samples `pdIn` low after it was sampled high.
- R3: `zeroSel` stays high for exactly CAL_FRAMES (default 4096) frame strobes. It falls at the edge that takes the last of them.
- R4: After calibration, a settling wait of exactly SETTLE_FRAMES (default 40) frame strobes follows, with `zeroSel` low and `calBusy` high. `calBusy` falls at the edge that takes the last strobe.
- R5: `calBusy` is high from the start of calibration to the end of the settling wait. `zeroSel` is never high without `calBusy`.
- R6: Clock cycles without a frame strobe never advance the sequence, whatever the spacing of the strobes.
- R7: For each channel, the offset is the two's-complement sum of all CAL_FRAMES samples taken on strobes during calibration, including the last one, shifted arithmetically right by log2(CAL_FRAMES). This rounds toward minus infinity. The two channels are independent.
- R8: In normal operation, each output is registered one cycle after its input and equals the input minus that channel's offset, clamped to the signed range of SAMPLE_W bits (-32768..32767 by default).
- R9: Outputs are zero in every cycle that follows a cycle of calibration or settling.
- R10: A rising `pdIn` at any point, including the same cycle as the final settling strobe, aborts the sequence. The next falling edge starts a fresh calibration whose offset reflects only its own samples.
- R11: Holding `pdIn` low from reset, with no falling edge, never starts a calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frameStb | input | 1 | One-cycle strobe per left/right frame |
| pdIn | input | 1 | Digital power-down request, active high |
| sampleL | input | SAMPLE_W | Signed left sample from the decimation filter |
| sampleR | input | SAMPLE_W | Signed right sample from the decimation filter |
| zeroSel | output | 1 | Routes the modulators to the zero-reference inputs |
| calBusy | output | 1 | High during calibration and settling |
| outL | output | SAMPLE_W | Offset-corrected left sample |
| outR | output | SAMPLE_W | Offset-corrected right sample |

## Verification
On the final calibration strobe, the block must add the last sample and latch the offset on the same edge. The bench makes that last left sample far larger than the others, so a latch that drops it gives a visibly different corrected output. A power-down request can also arrive on the same edge as the final settling strobe. The bench raises `pdIn` together with that strobe and expects the abort to win: `calBusy` low and outputs zero, never a cycle of corrected data.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [1:0] {
    PH_DOWN,
    PH_CAL,
    PH_SETTLE,
    PH_RUN
  } phase_t;

  typedef struct packed {
    logic clearAll;
    logic accumulate;
    logic latchOffset;
    logic passData;
  } dpCtrl_t;
endpackage

// File: rtl/ocs_ctrl.sv
module ocs_ctrl
  import ocs_pkg::*;
#(
  parameter int CAL_FRAMES    = 4096,
  parameter int SETTLE_FRAMES = 40
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    frameStb,
  input  logic    pdIn,
  output dpCtrl_t ctrl,
  output logic    zeroSel,
  output logic    calBusy
);
  localparam int MAX_FR = (CAL_FRAMES > SETTLE_FRAMES) ? CAL_FRAMES : SETTLE_FRAMES;
  localparam int CNT_W  = $clog2(MAX_FR + 1);
  localparam logic [CNT_W-1:0] CAL_LAST    = CNT_W'(CAL_FRAMES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_FRAMES - 1);

  phase_t           phase;
  logic             pdPrev;
  logic [CNT_W-1:0] frameCnt;
  logic             pdFell;
  logic             calLast;
  logic             settleLast;

  assign pdFell     = pdPrev & ~pdIn;
  assign calLast    = (phase == PH_CAL) && frameStb && (frameCnt == CAL_LAST);
  assign settleLast = (phase == PH_SETTLE) && frameStb && (frameCnt == SETTLE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pdPrev   <= 1'b0;
      phase    <= PH_DOWN;
      frameCnt <= '0;
    end else begin
      pdPrev <= pdIn;
      if (pdIn) begin
        phase    <= PH_DOWN;
        frameCnt <= '0;
      end else begin
        unique case (phase)
          PH_DOWN: begin
            if (pdFell) begin
              phase    <= PH_CAL;
              frameCnt <= '0;
            end
          end
          PH_CAL: begin
            if (calLast) begin
              phase    <= PH_SETTLE;
              frameCnt <= '0;
            end else if (frameStb) begin
              frameCnt <= frameCnt + CNT_W'(1);
            end
          end
          PH_SETTLE: begin
            if (settleLast) begin
              phase    <= PH_RUN;
              frameCnt <= '0;
            end else if (frameStb) begin
              frameCnt <= frameCnt + CNT_W'(1);
            end
          end
          default: phase <= PH_RUN;
        endcase
      end
    end
  end

  always_comb begin
    ctrl.clearAll    = pdIn;
    ctrl.accumulate  = (phase == PH_CAL) && frameStb && !pdIn;
    ctrl.latchOffset = calLast && !pdIn;
    ctrl.passData    = (phase == PH_RUN);
  end

  assign zeroSel = (phase == PH_CAL);
  assign calBusy = (phase == PH_CAL) || (phase == PH_SETTLE);
endmodule

// File: rtl/ocs_dp.sv
module ocs_dp
  import ocs_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int CAL_SHIFT = 12,
  parameter int NCH       = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  dpCtrl_t             ctrl,
  input  logic [SAMPLE_W-1:0] sampleIn  [NCH],
  output logic [SAMPLE_W-1:0] sampleOut [NCH]
);
  localparam int ACC_W = SAMPLE_W + CAL_SHIFT;
  localparam logic [SAMPLE_W-1:0] POS_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_MAX = {1'b1, {(SAMPLE_W-1){1'b0}}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [ACC_W-1:0]    acc;
    logic [ACC_W-1:0]    accNext;
    logic [SAMPLE_W-1:0] offset;
    logic [SAMPLE_W:0]   diff;
    logic [SAMPLE_W-1:0] corrected;

    assign accNext = acc + {{CAL_SHIFT{sampleIn[ch][SAMPLE_W-1]}}, sampleIn[ch]};
    assign diff    = {sampleIn[ch][SAMPLE_W-1], sampleIn[ch]} - {offset[SAMPLE_W-1], offset};

    always_comb begin
      if (diff[SAMPLE_W] != diff[SAMPLE_W-1]) begin
        corrected = diff[SAMPLE_W] ? NEG_MAX : POS_MAX;
      end else begin
        corrected = diff[SAMPLE_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst || ctrl.clearAll) begin
        acc    <= '0;
        offset <= '0;
      end else begin
        if (ctrl.accumulate) begin
          acc <= accNext;
        end
        if (ctrl.latchOffset) begin
          offset <= accNext[ACC_W-1:CAL_SHIFT];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst || !ctrl.passData) begin
        sampleOut[ch] <= '0;
      end else begin
        sampleOut[ch] <= corrected;
      end
    end
  end
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import ocs_pkg::*;
#(
  parameter int SAMPLE_W      = 16,
  parameter int CAL_FRAMES    = 4096,
  parameter int SETTLE_FRAMES = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frameStb,
  input  logic                pdIn,
  input  logic [SAMPLE_W-1:0] sampleL,
  input  logic [SAMPLE_W-1:0] sampleR,
  output logic                zeroSel,
  output logic                calBusy,
  output logic [SAMPLE_W-1:0] outL,
  output logic [SAMPLE_W-1:0] outR
);
  localparam int CAL_SHIFT = $clog2(CAL_FRAMES);

  dpCtrl_t             ctrl;
  logic [SAMPLE_W-1:0] chanIn  [2];
  logic [SAMPLE_W-1:0] chanOut [2];

  assign chanIn[0] = sampleL;
  assign chanIn[1] = sampleR;
  assign outL      = chanOut[0];
  assign outR      = chanOut[1];

  ocs_ctrl #(
    .CAL_FRAMES   (CAL_FRAMES),
    .SETTLE_FRAMES(SETTLE_FRAMES)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .frameStb(frameStb),
    .pdIn    (pdIn),
    .ctrl    (ctrl),
    .zeroSel (zeroSel),
    .calBusy (calBusy)
  );

  ocs_dp #(
    .SAMPLE_W (SAMPLE_W),
    .CAL_SHIFT(CAL_SHIFT),
    .NCH      (2)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .sampleIn (chanIn),
    .sampleOut(chanOut)
  );
endmodule

// File: rtl/offset_cal_seq_chk.sv
module offset_cal_seq_chk #(
  parameter int SAMPLE_W      = 16,
  parameter int CAL_FRAMES    = 4096,
  parameter int SETTLE_FRAMES = 40
) (
  input logic                clk,
  input logic                rst,
  input logic                frameStb,
  input logic                pdIn,
  input logic                zeroSel,
  input logic                calBusy,
  input logic [SAMPLE_W-1:0] outL,
  input logic [SAMPLE_W-1:0] outR
);
  int calCnt;
  int setCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      calCnt <= 0;
      setCnt <= 0;
    end else begin
      if (zeroSel && frameStb) calCnt <= calCnt + 1;
      else if (!zeroSel)       calCnt <= 0;
      if (calBusy && !zeroSel && frameStb) setCnt <= setCnt + 1;
      else if (!calBusy || zeroSel)        setCnt <= 0;
    end
  end

  AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    pdIn |=> (!calBusy && !zeroSel)); // R1
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(calBusy) |-> (zeroSel && !$past(pdIn) && $past(pdIn, 2))); // R2
  AST_CAL_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(zeroSel) && calBusy) |-> (calCnt == CAL_FRAMES)); // R3
  AST_SETTLE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(calBusy) && !$past(pdIn)) |-> (setCnt == SETTLE_FRAMES)); // R4
  AST_SEL_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    zeroSel |-> calBusy); // R5
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!frameStb && !pdIn && !$past(pdIn)) |=> ($stable(zeroSel) && $stable(calBusy))); // R6
  AST_ZERO_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    calBusy |=> (outL == '0 && outR == '0)); // R9
  AST_ZERO_WHEN_DOWN: assert property (@(posedge clk) disable iff (rst)
    (pdIn && $past(pdIn)) |=> (outL == '0 && outR == '0)); // R1
endmodule

bind offset_cal_seq offset_cal_seq_chk #(
  .SAMPLE_W     (SAMPLE_W),
  .CAL_FRAMES   (CAL_FRAMES),
  .SETTLE_FRAMES(SETTLE_FRAMES)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .frameStb(frameStb),
  .pdIn    (pdIn),
  .zeroSel (zeroSel),
  .calBusy (calBusy),
  .outL    (outL),
  .outR    (outR)
);

// File: tb/offset_cal_seq_tb_top.sv
module offset_cal_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW         = 16;
  localparam int CALN       = 4096;
  localparam int SETN       = 40;

  logic          clk      = 1'b0;
  logic          rst      = 1'b1;
  logic          frameStb = 1'b0;
  logic          pdIn     = 1'b0;
  logic [SW-1:0] sampleL  = '0;
  logic [SW-1:0] sampleR  = '0;
  logic          zeroSel;
  logic          calBusy;
  logic [SW-1:0] outL;
  logic [SW-1:0] outR;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [SW-1:0] l;
    logic [SW-1:0] r;
    string         req;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  offset_cal_seq #(
    .SAMPLE_W(SW), .CAL_FRAMES(CALN), .SETTLE_FRAMES(SETN)
  ) dut_i (
    .clk(clk), .rst(rst), .frameStb(frameStb), .pdIn(pdIn),
    .sampleL(sampleL), .sampleR(sampleR),
    .zeroSel(zeroSel), .calBusy(calBusy), .outL(outL), .outR(outR)
  );

  function automatic logic [SW-1:0] sat16(longint v);
    if (v > 32767)  return 16'h7fff;
    if (v < -32768) return 16'h8000;
    return v[SW-1:0];
  endfunction

  function automatic int patL(int i, int k);
    if (k == 0) return 100 + (i % 5) * 7;
    return -2000 + (i % 11) * 3;
  endfunction

  function automatic int patR(int i, int k);
    if (k == 0) return -37 - (i % 3);
    return 500 + (i % 4);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares outputs after the edge that follows each pushed item
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      nChecks++;
      if (outL !== e.l || outR !== e.r) begin
        nFails++;
        $display("FAIL %s outputs: actual L=%0d R=%0d expected L=%0d R=%0d",
                 e.req, $signed(outL), $signed(outR), $signed(e.l), $signed(e.r));
      end
    end
  end

  task automatic pulse(int gap, int l, int r);
    @(negedge clk);
    frameStb = 1'b1;
    sampleL  = l[SW-1:0];
    sampleR  = r[SW-1:0];
    @(negedge clk);
    frameStb = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expectZero(string req);
    exp_t e;
    @(negedge clk);
    sampleL = 16'd1234;
    sampleR = 16'd4321;
    e.l = '0; e.r = '0; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic expectRun(int l, int r, longint offL, longint offR, string req);
    exp_t e;
    @(negedge clk);
    sampleL = l[SW-1:0];
    sampleR = r[SW-1:0];
    e.l = sat16(longint'(l) - offL);
    e.r = sat16(longint'(r) - offR);
    e.req = req;
    expQ.push_back(e);
  endtask

  task automatic startCal();
    @(negedge clk);
    pdIn = 1'b0;
    check(!calBusy, "R2", "busy before sampling edge", calBusy, 0);
    @(negedge clk);
    check(calBusy && zeroSel, "R2", "busy/select after fall", {calBusy, zeroSel}, 3);
  endtask

  task automatic runCal(int k, bit bigLast, output longint offL, output longint offR);
    longint sumL = 0;
    longint sumR = 0;
    for (int i = 0; i < CALN; i++) begin
      int l = (bigLast && i == CALN - 1) ? 30000 : patL(i, k);
      int r = patR(i, k);
      sumL += l;
      sumR += r;
      pulse((i % 3 == 0) ? 2 : 0, l, r);
      if (i == 100) begin
        repeat (9) @(negedge clk);
        check(zeroSel, "R6", "select held through idle gap", zeroSel, 1);
        expectZero("R9");
      end
      if (i == CALN - 2) check(zeroSel, "R3", "select before last strobe", zeroSel, 1);
    end
    check(!zeroSel && calBusy, "R3", "select/busy after last cal strobe", {zeroSel, calBusy}, 1);
    offL = sumL >>> 12;
    offR = sumR >>> 12;
  endtask

  task automatic runSettle(int count);
    for (int i = 0; i < count; i++) begin
      pulse(i % 2, 77, -77);
      if (i == 10) expectZero("R9");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    longint oL, oR;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: pdIn low from reset never starts calibration
    repeat (20) @(negedge clk);
    check(!calBusy && !zeroSel, "R11", "idle with pd low", {calBusy, zeroSel}, 0);
    expectZero("R11");

    // R1: power-down state
    @(negedge clk); pdIn = 1'b1;
    repeat (5) @(negedge clk);
    check(!calBusy && !zeroSel, "R1", "power-down flags", {calBusy, zeroSel}, 0);
    expectZero("R1");

    // First calibration, big last sample (R7 inclusion)
    startCal();
    runCal(0, 1'b1, oL, oR);
    runSettle(SETN - 1);
    check(calBusy && !zeroSel, "R4", "still settling before last strobe", {calBusy, zeroSel}, 2);
    pulse(0, 5, 5);
    check(!calBusy && !zeroSel, "R5", "busy ends with settle", {calBusy, zeroSel}, 0);
    expectRun(0, 0, oL, oR, "R7");
    expectRun(1000, -1000, oL, oR, "R8");
    expectRun(-32768, 32767, oL, oR, "R8");
    expectRun(32767, -32768, oL, oR, "R8");

    // R10: abort during run, then abort mid-calibration
    @(negedge clk); pdIn = 1'b1;
    @(negedge clk);
    check(!calBusy && !zeroSel, "R10", "flags after abort", {calBusy, zeroSel}, 0);
    expectZero("R10");
    repeat (3) @(negedge clk);
    startCal();
    for (int i = 0; i < 1000; i++) pulse(0, 30000, -30000);
    @(negedge clk); pdIn = 1'b1;
    @(negedge clk);
    check(!calBusy && !zeroSel, "R10", "abort during calibration", {calBusy, zeroSel}, 0);
    repeat (3) @(negedge clk);
    startCal();
    runCal(1, 1'b0, oL, oR);
    runSettle(SETN);
    check(!calBusy, "R4", "settle complete", calBusy, 0);
    expectRun(0, 0, oL, oR, "R10");
    expectRun(-31000, 32000, oL, oR, "R7");
    expectRun(32767, -32768, oL, oR, "R8");

    // R10: power-down on the same edge as the final settling strobe
    @(negedge clk); pdIn = 1'b1;
    repeat (3) @(negedge clk);
    startCal();
    runCal(0, 1'b0, oL, oR);
    runSettle(SETN - 1);
    @(negedge clk);
    frameStb = 1'b1;
    pdIn     = 1'b1;
    @(negedge clk);
    frameStb = 1'b0;
    check(!calBusy && !zeroSel, "R10", "abort wins on last settle strobe", {calBusy, zeroSel}, 0);
    expectZero("R10");
    expectZero("R1");
    repeat (5) @(negedge clk);
    check(!calBusy, "R1", "stays down", calBusy, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule